// File: doc/BRIEF.md
# Grouped Interrupt Aggregator

This block gathers a parameterized set of interrupt source lines (32 by default) into one group with a small memory-mapped register set. A rising edge on any source line is captured in a sticky status bit, whether or not that line is enabled. Software acknowledges events by writing ones to the status word.

Each line has an enable bit. The enable mask cannot be written directly. It is changed through two aliased words: one sets bits where ones are written, the other clears bits where ones are written, and both read back the current mask. A read-only word returns status masked by enable. The group drives a single interrupt request, which is the registered OR of those masked bits.

The register word is chosen by byte address bits above the two lowest. Reads are combinational from the address. Writes take effect at the clock edge on which `wrEn` is high.

Top module: `irq_group_agg`

## Requirements
- R1: After reset, status and enable are all zero, `irqOut` is low, and every register word reads zero.
- R2: A 0-to-1 transition of `srcIn[i]` sets status bit i at the next clock edge, whatever the enable bit. A line held high does not set the bit again once it has been cleared.
- R3: A write to byte offset 0x0 clears each status bit where `wrData` has a one. Zeros leave bits unchanged. Reading offset 0x0 returns status.
- R4: When a new rising edge on line i arrives in the same cycle as a write-1-to-clear of status bit i, the bit stays set.
- R5: A write to offset 0x4 sets each enable bit where `wrData` has a one. Zeros leave bits unchanged. Reading offset 0x4 returns the enable mask.
- R6: A write to offset 0xC clears each enable bit where `wrData` has a one. Reading offset 0xC returns the enable mask.
- R7: Offset 0x8 reads status AND enable, and writes to it change nothing.
- R8: Offset 0x10 reads zero, and writes to it change nothing.
- R9: `irqOut` is high in the cycle after any bit of status AND enable is one, and low in the cycle after none is.
- R10: With `wrEn` low, no register changes, whatever `addr` and `wrData` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Interrupt source lines |
| wrEn | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Byte address of the register word |
| wrData | input | NUM_SRC | Write data |
| rdData | output | NUM_SRC | Read data for the addressed word |
| irqOut | output | 1 | Registered group interrupt request |

## Verification
A corrupted status or enable bit shows up immediately on a read of offset 0x0, 0x4 or 0xC. One cycle later it also shows on `irqOut`, provided the matching bit of the other register is set. A wrong edge detector shows up as a missing status bit one edge after a rise, or as a bit that comes back after it was cleared while the line stays high. Each vector changes state in one clock and then reads a chosen word. This exposes a mis-decoded alias or a write that leaks into the read-only or reserved word within a single cycle.

// File: rtl/intgrp_pkg.sv
package intgrp_pkg;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_EN_SET = 3'd1,
    SEL_RESULT = 3'd2,
    SEL_EN_CLR = 3'd3,
    SEL_NONE   = 3'd4
  } regSel_e;

  typedef struct packed {
    logic    clrStatus;
    logic    setEnable;
    logic    clrEnable;
    regSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/intgrp_ctrl.sv
module intgrp_ctrl
  import intgrp_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strobes
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  assign wordIdx = addr[ADDR_W-1:2];

  always_comb begin
    strobes = '{clrStatus: 1'b0, setEnable: 1'b0, clrEnable: 1'b0, rdSel: SEL_NONE};
    case (wordIdx)
      IDX_W'(0): strobes.rdSel = SEL_STATUS;
      IDX_W'(1): strobes.rdSel = SEL_EN_SET;
      IDX_W'(2): strobes.rdSel = SEL_RESULT;
      IDX_W'(3): strobes.rdSel = SEL_EN_CLR;
      default:   strobes.rdSel = SEL_NONE;
    endcase
    strobes.clrStatus = wrEn && (wordIdx == IDX_W'(0));
    strobes.setEnable = wrEn && (wordIdx == IDX_W'(1));
    strobes.clrEnable = wrEn && (wordIdx == IDX_W'(3));
  end

  // R10: an idle bus raises no write strobe.
  always_comb begin
    a_r10_no_strobe_idle: assert (wrEn || !(strobes.clrStatus || strobes.setEnable || strobes.clrEnable));
  end

endmodule

// File: rtl/intgrp_dp.sv
module intgrp_dp
  import intgrp_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  strobe_t            strobes,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] srcPrevQ, srcEvent, statusQ, enableQ, resultBits;
  logic [NUM_SRC-1:0] stClrMask, enSetMask, enClrMask;
  logic               irqQ;

  assign srcEvent   = srcIn & ~srcPrevQ;
  assign stClrMask  = strobes.clrStatus ? wrData : '0;
  assign enSetMask  = strobes.setEnable ? wrData : '0;
  assign enClrMask  = strobes.clrEnable ? wrData : '0;
  assign resultBits = statusQ & enableQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcPrevQ <= '0;
    else       srcPrevQ <= srcIn;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_status
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             statusQ[i] <= 1'b0;
      else if (srcEvent[i])  statusQ[i] <= 1'b1;
      else if (stClrMask[i]) statusQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enableQ <= '0;
    else       enableQ <= (enableQ | enSetMask) & ~enClrMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |resultBits;
  end
  assign irqOut = irqQ;

  always_comb begin
    case (strobes.rdSel)
      SEL_STATUS: rdData = statusQ;
      SEL_EN_SET: rdData = enableQ;
      SEL_RESULT: rdData = resultBits;
      SEL_EN_CLR: rdData = enableQ;
      default:    rdData = '0;
    endcase
  end

  // R2 / R4: every detected edge is present in status after the edge.
  a_r2_edge_latched: assert property (@(posedge clk) disable iff (!rstN)
    ($past(srcEvent) & ~statusQ) == '0);

  // R3: a status bit only falls when a clear was written for it.
  a_r3_clear_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statusQ) & ~statusQ & ~$past(stClrMask)) == '0);

  // R5 / R6 / R10: enable moves only under a set or clear alias strobe.
  a_r5_enable_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.setEnable && !strobes.clrEnable) |=> $stable(enableQ));

  // R9: interrupt follows the masked status one cycle later.
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(statusQ & enableQ))));

endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg
  import intgrp_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut
);
  strobe_t strobes;

  intgrp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn    (wrEn),
    .addr    (addr),
    .strobes (strobes)
  );

  intgrp_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .strobes (strobes),
    .wrData  (wrData),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/tb_irq_group_agg.sv
module tb_irq_group_agg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  irq_group_agg dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [31:0] src;
    logic        we;
    logic [4:0]  waddr;
    logic [31:0] wdata;
    logic [4:0]  raddr;
    logic [31:0] expRd;
    logic        expIrq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h1,        1'b0, 5'h00, 32'h0,        5'h00, 32'h1,        1'b0, 8'd2},  // R2 latch while disabled
    '{32'h1,        1'b1, 5'h04, 32'h3,        5'h08, 32'h1,        1'b0, 8'd7},  // R5 set, R7 result
    '{32'h1,        1'b0, 5'h00, 32'h0,        5'h04, 32'h3,        1'b1, 8'd9},  // R9 irq rises
    '{32'h1,        1'b1, 5'h00, 32'h1,        5'h00, 32'h0,        1'b1, 8'd3},  // R3 clear, held line no relatch
    '{32'h0,        1'b0, 5'h00, 32'h0,        5'h08, 32'h0,        1'b0, 8'd9},  // R9 irq falls
    '{32'h2,        1'b1, 5'h00, 32'h2,        5'h00, 32'h2,        1'b0, 8'd4},  // R4 event beats clear
    '{32'h0,        1'b1, 5'h0C, 32'h1,        5'h0C, 32'h2,        1'b1, 8'd6},  // R6 clear enable
    '{32'h0,        1'b1, 5'h08, 32'hFFFFFFFF, 5'h08, 32'h2,        1'b1, 8'd7},  // R7 write ignored
    '{32'h0,        1'b1, 5'h10, 32'hFFFFFFFF, 5'h10, 32'h0,        1'b1, 8'd8},  // R8 reserved
    '{32'h0,        1'b1, 5'h0C, 32'h2,        5'h04, 32'h0,        1'b1, 8'd6},  // R6 alias read
    '{32'h0,        1'b0, 5'h00, 32'h0,        5'h08, 32'h0,        1'b0, 8'd9},  // R9 masked off
    '{32'h0,        1'b1, 5'h00, 32'h0,        5'h00, 32'h2,        1'b0, 8'd3},  // R3 zeros no effect
    '{32'h0,        1'b0, 5'h00, 32'hFFFFFFFF, 5'h00, 32'h2,        1'b0, 8'd10}, // R10 no write
    '{32'hFFFFFFFF, 1'b0, 5'h00, 32'h0,        5'h00, 32'hFFFFFFFF, 1'b0, 8'd2},  // R2 all lines
    '{32'hFFFFFFFF, 1'b1, 5'h00, 32'hFFFFFFFF, 5'h00, 32'h0,        1'b0, 8'd3},  // R3 clear all
    '{32'hFFFFFFFF, 1'b1, 5'h04, 32'h0,        5'h04, 32'h0,        1'b0, 8'd5}   // R5 zeros no effect
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic readCheck(input logic [4:0] a, input logic [31:0] exp, input string tag);
    wrEn = 1'b0;
    addr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  initial begin
    #20000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    for (int w = 0; w < 5; w++) readCheck(5'(w * 4), 32'h0, "R1 read");

    for (int v = 0; v < NV; v++) begin
      srcIn  = VECS[v].src;
      wrEn   = VECS[v].we;
      addr   = VECS[v].waddr;
      wrData = VECS[v].wdata;
      @(posedge clk);
      @(negedge clk);
      readCheck(VECS[v].raddr, VECS[v].expRd, $sformatf("R%0d read v%0d", VECS[v].req, v));
      check($sformatf("R%0d irq v%0d", VECS[v].req, v), {31'b0, irqOut}, {31'b0, VECS[v].expIrq});
    end

    // R1: reset in the middle of activity clears everything
    srcIn = 32'h0;
    wrEn = 1'b1; addr = 5'h04; wrData = 32'hFFFFFFFF;
    @(posedge clk); @(negedge clk);
    srcIn = 32'h10;
    wrEn = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R9 irq before reset", {31'b0, irqOut}, 32'h1);
    srcIn = 32'h0;
    rstN = 1'b0;
    #1;
    check("R1 irq in reset", {31'b0, irqOut}, 32'h0);
    readCheck(5'h04, 32'h0, "R1 enable in reset");
    readCheck(5'h00, 32'h0, "R1 status in reset");
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    readCheck(5'h0C, 32'h0, "R1 enable after reset");
    check("R1 irq after reset", {31'b0, irqOut}, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule